// File: doc/BRIEF.md
# Big-Endian Byte-Addressed Word Memory

This block is a processor data memory whose storage cells are single bytes while every access moves a full 32-bit word. A word read at address A collects the cells A, A+1, A+2 and A+3 and places the byte at A in the most significant position. A word write does the reverse and spreads the four bytes of the write data over those same cells, most significant byte first. Because each access is simply four consecutive cells, an address that is not a multiple of four needs no special handling. Such an access just straddles two aligned words.

The main control of the processor drives separate read and write enables. A write takes effect on the rising clock edge. A read is combinational and returns zero whenever the read enable is low. Reset clears every cell, so a location that has not been written since reset reads as zero. The low address bits select a cell, and the four-cell window wraps around the end of the array. Higher address bits play no part in the selection.

Top module: `be_byte_mem`

## Requirements
- R1: After reset is released, every cell holds 0x00, so any word read returns 0x00000000 until that location is written.
- R2: A word read at address A returns {cell[A], cell[A+1], cell[A+2], cell[A+3]}, with cell[A] in bits 31..24 and cell[A+3] in bits 7..0.
- R3: A write at address A with wr_en high stores wdata[31:24] in cell A, wdata[23:16] in cell A+1, wdata[15:8] in cell A+2 and wdata[7:0] in cell A+3 at the rising clock edge.
- R4: An address that is not a multiple of four is handled like any other address, so a write at such an address shows up split across the two aligned words it straddles.
- R5: Cell indices wrap modulo the depth (1024 by default). A word at 0x3FE covers cells 0x3FE, 0x3FF, 0x000 and 0x001.
- R6: While rd_en is low, rdata is 0x00000000 regardless of the address or the stored contents.
- R7: While wr_en is low, no cell changes, whatever values addr and wdata carry.
- R8: rdata follows addr and rd_en within the same cycle, and a word written at an edge is visible in the cycle right after that edge.
- R9: Only the low log2(depth) address bits select cells. Addresses that differ only above those bits reach the same cells.
- R10: Two overlapping writes leave the bytes of the later write in the shared cells and keep the earlier write's bytes in the cells only it touched.
- R11: When a read and a write to the same address occur in the same cycle, the read returns the contents from before that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; writes occur on its rising edge |
| rst_n | input | 1 | Active-low reset; clears every cell |
| addr | input | ADDR_W (32) | Byte address of the first (most significant) byte |
| wdata | input | 32 | Word to be written |
| wr_en | input | 1 | Write enable from the processor's main control |
| rd_en | input | 1 | Read enable; rdata is zero when low |
| rdata | output | 32 | Assembled big-endian read word |

## Verification
The hardest case to reach from the ports is the wrap at the top of the array, because the window there splits between the last cells and the first ones. The stimulus writes a word at 0x3FE. It then reads the words at 0x3FC and 0x000 and checks that each shows only its own half of the written word. Read-during-write is reached by raising both enables at one address in the same cycle and checking the old word first and then the new word in the next cycle. Aliasing is exercised by reaching written cells through addresses with high bits set.

// File: rtl/bemem_pkg.sv
package bemem_pkg;
    localparam int BYTE_W  = 8;
    localparam int LANES   = 4;
    localparam int WORD_W  = BYTE_W * LANES;

    typedef logic [BYTE_W-1:0] byte_t;
endpackage

// File: rtl/bemem_lane_index.sv
module bemem_lane_index #(
    parameter int IDX_W = 10,
    parameter int LANES = 4
) (
    input  logic [IDX_W-1:0]            base_idx,
    output logic [LANES-1:0][IDX_W-1:0] lane_idx
);
    // Lane 0 is the most significant byte at the base address; the lanes
    // after it step upward and wrap naturally at the array size.
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assign lane_idx[l] = IDX_W'(base_idx + IDX_W'(l));
    end
endmodule

// File: rtl/bemem_word_pack.sv
module bemem_word_pack #(
    parameter int LANES  = 4,
    parameter int BYTE_W = 8
) (
    input  logic [LANES*BYTE_W-1:0]      word_in,
    output logic [LANES-1:0][BYTE_W-1:0] lanes_out,
    input  logic [LANES-1:0][BYTE_W-1:0] lanes_in,
    output logic [LANES*BYTE_W-1:0]      word_out
);
    // Big-endian mapping: lane 0 <-> top byte of the word.
    for (genvar l = 0; l < LANES; l++) begin : g_map
        localparam int LSB = (LANES - 1 - l) * BYTE_W;
        assign lanes_out[l]               = word_in[LSB +: BYTE_W];
        assign word_out[LSB +: BYTE_W]    = lanes_in[l];
    end
endmodule

// File: rtl/bemem_byte_array.sv
module bemem_byte_array #(
    parameter int DEPTH  = 1024,
    parameter int IDX_W  = 10,
    parameter int LANES  = 4,
    parameter int BYTE_W = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic [LANES-1:0][IDX_W-1:0]  lane_idx,
    input  logic [LANES-1:0][BYTE_W-1:0] wr_bytes,
    output logic [LANES-1:0][BYTE_W-1:0] rd_bytes
);
    logic [BYTE_W-1:0] cell_q [DEPTH];
    logic [BYTE_W-1:0] cell_d [DEPTH];

    // Next-state: copy of the array with the addressed lanes replaced.
    always_comb begin
        cell_d = cell_q;
        if (wr_en) begin
            for (int l = 0; l < LANES; l++) begin
                cell_d[lane_idx[l]] = wr_bytes[l];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                cell_q[i] <= '0;
            end
        end else begin
            cell_q <= cell_d;
        end
    end

    // Reads come straight from the registered cells.
    for (genvar l = 0; l < LANES; l++) begin : g_rd
        assign rd_bytes[l] = cell_q[lane_idx[l]];
    end
endmodule

// File: rtl/be_byte_mem.sv
module be_byte_mem #(
    parameter int ADDR_W = 32,
    parameter int DEPTH  = 1024
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [ADDR_W-1:0]          addr,
    input  logic [bemem_pkg::WORD_W-1:0] wdata,
    input  logic                       wr_en,
    input  logic                       rd_en,
    output logic [bemem_pkg::WORD_W-1:0] rdata
);
    import bemem_pkg::*;

    localparam int IDX_W = $clog2(DEPTH);

    logic [LANES-1:0][IDX_W-1:0]  lane_idx;
    logic [LANES-1:0][BYTE_W-1:0] wr_bytes;
    logic [LANES-1:0][BYTE_W-1:0] rd_bytes;
    logic [WORD_W-1:0]            rd_word;

    // Address bits above the cell index take no part in selection.
    if (ADDR_W > IDX_W) begin : g_hi
        logic unused_hi;
        assign unused_hi = ^addr[ADDR_W-1:IDX_W];
    end

    bemem_lane_index #(
        .IDX_W (IDX_W),
        .LANES (LANES)
    ) u_idx (
        .base_idx (addr[IDX_W-1:0]),
        .lane_idx (lane_idx)
    );

    bemem_word_pack #(
        .LANES  (LANES),
        .BYTE_W (BYTE_W)
    ) u_pack (
        .word_in   (wdata),
        .lanes_out (wr_bytes),
        .lanes_in  (rd_bytes),
        .word_out  (rd_word)
    );

    bemem_byte_array #(
        .DEPTH  (DEPTH),
        .IDX_W  (IDX_W),
        .LANES  (LANES),
        .BYTE_W (BYTE_W)
    ) u_arr (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .lane_idx (lane_idx),
        .wr_bytes (wr_bytes),
        .rd_bytes (rd_bytes)
    );

    assign rdata = rd_en ? rd_word : '0;
endmodule

// File: rtl/bemem_checker.sv
module bemem_checker #(
    parameter int ADDR_W = 32,
    parameter int WORD_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] addr,
    input logic [WORD_W-1:0] wdata,
    input logic              wr_en,
    input logic              rd_en,
    input logic [WORD_W-1:0] rdata
);
    // R1: first cycle out of reset sees an empty memory
    assert_reset_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> rdata == '0);

    // R3 / R8: a word written is read back whole at the same address next cycle
    assert_write_visible_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (!(rd_en && $stable(addr)) || rdata == $past(wdata)));

    // R6: disabled read drives zero
    assert_rd_off_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |-> rdata == '0);

    // R7: with no write, a held read of the same address does not change
    assert_no_write_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> (!(rd_en && $past(rd_en) && $stable(addr)) || $stable(rdata)));
endmodule

bind be_byte_mem bemem_checker #(
    .ADDR_W (ADDR_W),
    .WORD_W (bemem_pkg::WORD_W)
) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .addr  (addr),
    .wdata (wdata),
    .wr_en (wr_en),
    .rd_en (rd_en),
    .rdata (rdata)
);

// File: tb/be_byte_mem_tb.sv
module be_byte_mem_tb;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 32;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic [31:0]       wdata = '0;
    logic              wr_en = 1'b0;
    logic              rd_en = 1'b0;
    logic [31:0]       rdata;

    typedef struct {
        logic [31:0] exp;
        string       tag;
    } item_t;

    item_t sb_q[$];
    int    n_vec = 0;
    int    n_bad = 0;
    bit    done  = 1'b0;

    be_byte_mem #(.ADDR_W(ADDR_W), .DEPTH(1024)) u_dut (
        .clk   (clk),
        .rst_n (rst_n),
        .addr  (addr),
        .wdata (wdata),
        .wr_en (wr_en),
        .rd_en (rd_en),
        .rdata (rdata)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Driver tasks: each sets inputs for one cycle at the falling edge.
    task automatic put(input logic [31:0] a, input logic [31:0] d,
                       input logic we, input logic re,
                       input bit chk, input logic [31:0] exp, input string tag);
        @(negedge clk);
        addr  = a;
        wdata = d;
        wr_en = we;
        rd_en = re;
        if (chk) sb_q.push_back('{exp: exp, tag: tag});
    endtask

    task automatic wr(input logic [31:0] a, input logic [31:0] d);
        put(a, d, 1'b1, 1'b0, 1'b0, '0, "");
    endtask

    task automatic rd(input logic [31:0] a, input logic [31:0] exp, input string tag);
        put(a, 32'h0, 1'b0, 1'b1, 1'b1, exp, tag);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        wr_en = 1'b0;
        rd_en = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Monitor: compares outputs shortly after each falling edge.
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (sb_q.size() > 0) begin
                item_t it;
                it = sb_q.pop_front();
                n_vec++;
                if (rdata !== it.exp) begin
                    n_bad++;
                    $display("FAIL %s: rdata=%h expected=%h", it.tag, rdata, it.exp);
                end
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 50000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R1: empty after reset
        rd(32'h000, 32'h0, "R1 cell 0x000");
        rd(32'h3FC, 32'h0, "R1 cell 0x3FC");
        rd(32'h200, 32'h0, "R1 cell 0x200");

        // R2/R3: aligned write, big-endian placement
        wr(32'h010, 32'h11223344);
        rd(32'h010, 32'h11223344, "R2 aligned word");
        rd(32'h011, 32'h22334400, "R2 window shifted by one");
        rd(32'h00D, 32'h00000011, "R3 top byte at base address");
        rd(32'h013, 32'h44000000, "R3 low byte at base+3");

        // R4: unaligned write straddles two aligned words
        wr(32'h021, 32'hAABBCCDD);
        rd(32'h020, 32'h00AABBCC, "R4 lower aligned word");
        rd(32'h024, 32'hDD000000, "R4 upper aligned word");

        // R5: wrap at the top of the array
        wr(32'h3FE, 32'hCAFEF00D);
        rd(32'h3FE, 32'hCAFEF00D, "R5 wrapped word read");
        rd(32'h000, 32'hF00D0000, "R5 first cells hold tail");
        rd(32'h3FC, 32'h0000CAFE, "R5 last cells hold head");

        // R9: high address bits ignored
        rd(32'h410, 32'h11223344, "R9 alias read");
        wr(32'hFFFF_F030, 32'h01020304);
        rd(32'h030, 32'h01020304, "R9 alias write");

        // R6: read disabled
        put(32'h010, 32'h0, 1'b0, 1'b0, 1'b1, 32'h0, "R6 rd_en low");

        // R7: write disabled with live data
        put(32'h010, 32'hDEADBEEF, 1'b0, 1'b1, 1'b1, 32'h11223344, "R7 wr_en low same cycle");
        rd(32'h010, 32'h11223344, "R7 cells unchanged");

        // R10: overlapping writes
        wr(32'h040, 32'h11111111);
        wr(32'h042, 32'h22222222);
        rd(32'h040, 32'h11112222, "R10 shared cells take later write");
        rd(32'h044, 32'h22220000, "R10 later write tail");
        rd(32'h03E, 32'h00001111, "R10 earlier-only cells kept");

        // R11 / R8: read during write returns old, new visible next cycle
        put(32'h010, 32'h55667788, 1'b1, 1'b1, 1'b1, 32'h11223344, "R11 old data on same-cycle read");
        rd(32'h010, 32'h55667788, "R8 new data next cycle");

        // R1: reset clears written cells
        do_reset();
        rd(32'h010, 32'h0, "R1 cleared after second reset");
        rd(32'h3FE, 32'h0, "R1 wrapped cells cleared");

        @(negedge clk);
        rd_en = 1'b0;
        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule